// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that finishes every instruction in one clock cycle. It fetches from a private instruction memory, reads two operands from a 32-entry register file, computes in an ALU, and optionally reads or writes a private data memory, all between two rising edges. It runs eight instructions: five register-to-register operations (add, subtract, AND, OR, signed set-on-less-than), a word load, a word store and a branch-if-equal.

The memories are preloaded through a load port that works only while reset is held. This lets a test environment place a program and its data without any external file. Two debug outputs make the running core visible: the current program counter, and one register chosen by a select input.

Top module: `scCore`

## Requirements
- R1: While `rst` is 1, `pcOut` is 0, the core writes neither a register nor data memory, and a high `loadEn` writes `loadData` into word `loadAddr` of instruction memory (`loadToData`=0) or data memory (`loadToData`=1).
- R2: Instruction word index is pc[AW+1:2]. When no branch is taken, the PC advances by 4 on each rising edge.
- R3: Opcode 000000 selects a register operation on rs=[25:21], rt=[20:16], writing rd=[15:11]. The func field [5:0] selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-on-less-than (result 1 or 0).
- R4: Opcode 100011 (load) writes data-memory word ((rs + sign-extended [15:0]) >> 2) into register rt.
- R5: Opcode 101011 (store) writes register rt into data-memory word ((rs + sign-extended [15:0]) >> 2). It writes no register.
- R6: Opcode 000100 (branch) compares rs with rt. When they are equal, the next PC is PC+4 + (sign-extended [15:0] << 2); otherwise it is PC+4. A branch writes nothing.
- R7: Register 0 always reads as zero. Writes that target it are discarded.
- R8: An undefined func under opcode 000000, or any other opcode, changes no register and no memory word, and the PC advances by 4.
- R9: `dbgData` shows register `dbgSel` combinationally.
- R10: A negative 16-bit offset is sign-extended, both for load/store addresses and for backward branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables the load port |
| loadEn | input | 1 | Load-port write strobe |
| loadToData | input | 1 | Load target: 0 instruction memory, 1 data memory |
| loadAddr | input | AW | Word index for the load-port write |
| loadData | input | 32 | Word written by the load port |
| pcOut | output | 32 | Address of the instruction now executing |
| dbgSel | input | 5 | Register number shown on `dbgData` |
| dbgData | output | 32 | Contents of the selected register |

## Verification
Two pieces of work share each cycle boundary. On one edge, a register or memory write lands. In the cycle that follows, the next instruction reads that same location combinationally. The program provokes this with back-to-back dependent register operations, and with a store followed at once by a load from the same word. The scoreboard judges it by the loaded and computed values that appear on the debug port, and by the PC trace, which shows whether each branch decision used the freshly written operands.

// File: rtl/scCorePkg.sv
package scCorePkg;

  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluOp_e;

  typedef struct packed {
    logic   regWrite;
    logic   regDst;
    logic   aluSrc;
    logic   memToReg;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    aluOp_e aluOp;
  } ctrl_t;

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/scControl.sv
module scControl
  import scCorePkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl       = '0;
    ctl.aluOp = ALU_ADD;
    unique case (opcode)
      OP_REG: begin
        ctl.regDst = 1'b1;
        ctl.regWrite = 1'b1;
        unique case (funct)
          FN_ADD:  ctl.aluOp = ALU_ADD;
          FN_SUB:  ctl.aluOp = ALU_SUB;
          FN_AND:  ctl.aluOp = ALU_AND;
          FN_OR:   ctl.aluOp = ALU_OR;
          FN_SLT:  ctl.aluOp = ALU_SLT;
          default: ctl.regWrite = 1'b0;   // R8: unknown func is inert
        endcase
      end
      OP_LOAD: begin
        ctl.regWrite = 1'b1;
        ctl.aluSrc   = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.memRead  = 1'b1;
      end
      OP_STORE: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.aluOp  = ALU_SUB;
      end
      default: ;                          // R8: unknown opcode is inert
    endcase
  end

endmodule

// File: rtl/scAlu.sv
module scAlu
  import scCorePkg::*;
(
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluOp_e          op,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  logic [XLEN-1:0] diff;
  assign diff = opA - opB;

  always_comb begin
    unique case (op)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = diff;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/scRegFile.sv
module scRegFile
  import scCorePkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wrEn,
  input  logic [RAW-1:0]  wrAddr,
  input  logic [XLEN-1:0] wrData,
  input  logic [RAW-1:0]  rdAddrA,
  output logic [XLEN-1:0] rdDataA,
  input  logic [RAW-1:0]  rdAddrB,
  output logic [XLEN-1:0] rdDataB,
  input  logic [RAW-1:0]  rdAddrDbg,
  output logic [XLEN-1:0] rdDataDbg
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (wrEn && wrAddr != '0) regs[wrAddr] <= wrData;
  end

  assign rdDataA   = (rdAddrA   == '0) ? '0 : regs[rdAddrA];
  assign rdDataB   = (rdAddrB   == '0) ? '0 : regs[rdAddrB];
  assign rdDataDbg = (rdAddrDbg == '0) ? '0 : regs[rdAddrDbg];

  // R7: a write aimed at register 0 never makes it read non-zero
  p_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == '0 && rdAddrDbg == '0) |-> rdDataDbg == '0);

endmodule

// File: rtl/scDatapath.sv
module scDatapath
  import scCorePkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            loadEn,
  input  logic            loadToData,
  input  logic [AW-1:0]   loadAddr,
  input  logic [XLEN-1:0] loadData,
  input  ctrl_t           ctl,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic [XLEN-1:0] pcOut,
  input  logic [RAW-1:0]  dbgSel,
  output logic [XLEN-1:0] dbgData
);

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0] pcReg, pcPlus4, brTarget, instr, immExt;
  logic [XLEN-1:0] rsData, rtData, aluB, aluRes, memRdData, wbData;
  logic [RAW-1:0]  dstReg;
  logic            aluZero, takeBranch, regWe, memWe;

  assign instr   = imem[pcReg[AW+1:2]];
  assign opcode  = instr[31:26];
  assign funct   = instr[5:0];
  assign immExt  = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign pcPlus4 = pcReg + 32'd4;
  assign brTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign takeBranch = ctl.branch & aluZero;

  always_ff @(posedge clk) begin
    if (rst)             pcReg <= '0;
    else if (takeBranch) pcReg <= brTarget;
    else                 pcReg <= pcPlus4;
  end

  assign regWe = ctl.regWrite & ~rst;
  assign memWe = ctl.memWrite & ~rst;
  assign dstReg = ctl.regDst ? instr[15:11] : instr[20:16];

  scRegFile u_rf (
    .clk(clk), .rst(rst),
    .wrEn(regWe), .wrAddr(dstReg), .wrData(wbData),
    .rdAddrA(instr[25:21]), .rdDataA(rsData),
    .rdAddrB(instr[20:16]), .rdDataB(rtData),
    .rdAddrDbg(dbgSel), .rdDataDbg(dbgData)
  );

  assign aluB = ctl.aluSrc ? immExt : rtData;

  scAlu u_alu (
    .opA(rsData), .opB(aluB), .op(ctl.aluOp),
    .result(aluRes), .zero(aluZero)
  );

  assign memRdData = dmem[aluRes[AW+1:2]];
  assign wbData    = ctl.memToReg ? memRdData : aluRes;

  always_ff @(posedge clk) begin
    if (rst && loadEn && !loadToData) imem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (rst && loadEn && loadToData) dmem[loadAddr] <= loadData;
    else if (memWe)                  dmem[aluRes[AW+1:2]] <= rtData;
  end

  assign pcOut = pcReg;

  // R2: sequential flow steps by one word
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !takeBranch |=> pcReg == $past(pcReg) + 32'd4);
  // R6: a taken branch lands on PC+4 plus the word offset
  p_branch_target_r6: assert property (@(posedge clk) disable iff (rst)
    takeBranch |=> pcReg == $past(pcPlus4) + ($past(immExt) << 2));
  // R5: a store never also writes a register
  p_store_no_reg_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.memWrite |-> !ctl.regWrite);
  // R4: memory read and write strobes are exclusive
  p_mem_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.memRead, ctl.memWrite}));
  // R3: set-on-less-than yields only 0 or 1
  p_slt_bool_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl.aluOp == ALU_SLT) |-> aluRes[XLEN-1:1] == '0);

endmodule

// File: rtl/scCore.sv
module scCore
  import scCorePkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loadEn,
  input  logic          loadToData,
  input  logic [AW-1:0] loadAddr,
  input  logic [31:0]   loadData,
  output logic [31:0]   pcOut,
  input  logic [4:0]    dbgSel,
  output logic [31:0]   dbgData
);

  ctrl_t      ctl;
  logic [5:0] opcode, funct;

  scControl u_ctl (.opcode(opcode), .funct(funct), .ctl(ctl));

  scDatapath #(.MEM_WORDS(MEM_WORDS)) u_dp (
    .clk(clk), .rst(rst),
    .loadEn(loadEn), .loadToData(loadToData), .loadAddr(loadAddr), .loadData(loadData),
    .ctl(ctl), .opcode(opcode), .funct(funct),
    .pcOut(pcOut), .dbgSel(dbgSel), .dbgData(dbgData)
  );

endmodule

// File: tb/sim_scCore.sv
module sim_scCore;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          loadEn = 1'b0;
  logic          loadToData = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [31:0]   loadData = '0;
  logic [31:0]   pcOut;
  logic [4:0]    dbgSel = '0;
  logic [31:0]   dbgData;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scCore #(.MEM_WORDS(64)) u0 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadData(loadData), .pcOut(pcOut),
    .dbgSel(dbgSel), .dbgData(dbgData)
  );

  typedef struct {
    logic [31:0] val;
    string       req;
  } pcItem_t;

  typedef struct {
    int          idx;
    logic [31:0] val;
    string       req;
  } regItem_t;

  pcItem_t  pcQ[$];
  regItem_t regQ[$];

  function automatic logic [31:0] rInst(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction

  function automatic logic [31:0] iInst(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic expectPc(logic [31:0] v, string req);
    pcItem_t it;
    it.val = v; it.req = req;
    pcQ.push_back(it);
  endtask

  task automatic expectReg(int idx, logic [31:0] v, string req);
    regItem_t it;
    it.idx = idx; it.val = v; it.req = req;
    regQ.push_back(it);
  endtask

  task automatic loadWord(bit toData, int addr, logic [31:0] w);
    @(negedge clk);
    loadEn = 1'b1; loadToData = toData; loadAddr = AW'(addr); loadData = w;
  endtask

  logic [31:0] prog [19];

  initial begin
    prog[0]  = iInst(6'b100011, 0, 1, 0);          // lw r1,0(r0)   = 5
    prog[1]  = iInst(6'b100011, 0, 2, 4);          // lw r2,4(r0)   = -3
    prog[2]  = rInst(1, 2, 3, 6'b100000);          // add r3 = 2
    prog[3]  = rInst(1, 2, 4, 6'b100010);          // sub r4 = 8
    prog[4]  = rInst(2, 4, 5, 6'b100100);          // and r5 = 8
    prog[5]  = rInst(1, 4, 6, 6'b100101);          // or  r6 = 13
    prog[6]  = rInst(2, 1, 7, 6'b101010);          // slt r7 = 1
    prog[7]  = rInst(1, 2, 8, 6'b101010);          // slt r8 = 0
    prog[8]  = rInst(1, 1, 0, 6'b100000);          // add r0 (discarded)
    prog[9]  = iInst(6'b101011, 4, 6, -4);         // sw r6,-4(r4) -> word 1
    prog[10] = iInst(6'b100011, 0, 9, 4);          // lw r9,4(r0)  = 13
    prog[11] = rInst(1, 1, 3, 6'b000000);          // undefined func
    prog[12] = iInst(6'b001000, 0, 4, 1);          // undefined opcode
    prog[13] = iInst(6'b000100, 1, 2, 5);          // beq not taken
    prog[14] = iInst(6'b000100, 5, 4, 2);          // beq taken -> 0x44
    prog[15] = rInst(1, 1, 3, 6'b100000);          // skipped
    prog[16] = rInst(1, 1, 5, 6'b100000);          // skipped
    prog[17] = rInst(6, 7, 12, 6'b100000);         // add r12 = 14
    prog[18] = iInst(6'b000100, 0, 0, -1);         // beq back to itself
  end

  // driver: preload and fill the scoreboard
  initial begin
    for (int i = 0; i < 19; i++) loadWord(1'b0, i, prog[i]);
    loadWord(1'b1, 0, 32'd5);
    loadWord(1'b1, 1, 32'hFFFF_FFFD);
    loadWord(1'b1, 2, 32'd7);
    @(negedge clk);
    loadEn = 1'b0;
    check("R1 pc held at zero in reset", pcOut, 32'h0);

    for (int i = 1; i <= 12; i++) expectPc(32'(4*i), "R2/R3/R4/R5/R8 sequential pc");
    expectPc(32'h34, "R8 undefined opcode advances pc");
    expectPc(32'h38, "R6 untaken branch");
    expectPc(32'h44, "R6 taken branch target");
    expectPc(32'h48, "R2 step after branch");
    for (int i = 0; i < 3; i++) expectPc(32'h48, "R10 backward branch offset");

    expectReg(0,  32'h0,        "R7 register 0 stays zero");
    expectReg(1,  32'd5,        "R4 load word 0");
    expectReg(2,  32'hFFFF_FFFD,"R4 load word 1");
    expectReg(3,  32'd2,        "R3 add; R8 undefined func; R6 skipped");
    expectReg(4,  32'd8,        "R3 sub; R8 undefined opcode");
    expectReg(5,  32'd8,        "R3 and; R6 skipped");
    expectReg(6,  32'd13,       "R3 or");
    expectReg(7,  32'd1,        "R3 signed slt true");
    expectReg(8,  32'd0,        "R3 signed slt false");
    expectReg(9,  32'd13,       "R5 store then R10 negative offset");
    expectReg(12, 32'd14,       "R9 debug read after branch");

    rst = 1'b0;
  end

  // monitor: compare design results against the scoreboard
  initial begin
    @(negedge rst);
    while (pcQ.size() > 0) begin
      pcItem_t it;
      @(negedge clk);
      it = pcQ.pop_front();
      check(it.req, pcOut, it.val);
    end
    while (regQ.size() > 0) begin
      regItem_t it;
      it = regQ.pop_front();
      dbgSel = 5'(it.idx);
      #1;
      check(it.req, dbgData, it.val);
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule